// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block holds the hazard logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that takes in one new instruction every clock. It is purely combinational. It reads the register numbers held in the decode, execute, memory and writeback pipeline registers, the write enables of the downstream stages, a load flag for the execute and memory stages, and the branch outcome computed in decode. From these it drives:

- a hold for the program counter and the fetch/decode latch,
- a bubble request for the decode/execute instruction register,
- a squash request for the fetch/decode instruction register,
- operand-select codes for the bypass multiplexers in front of the decode-stage comparator and in front of the execute-stage ALU.

Branches are resolved in decode. For that reason the block supplies bypass selects into decode as well as into execute. It also stalls a branch until its operands can actually reach decode. The interlocks do not rely on delay slots having been filled by software. The latches themselves, the register file and the datapath belong to the surrounding pipeline.

Top module: `hazard_ctrl`

## Requirements
- R1: With no producer in execute or memory matching a used decode source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 0, so one instruction is fetched every cycle.
- R2: When the execute stage holds a load (`ex_is_load`=1, `ex_wen`=1) whose nonzero `ex_rd` equals a used decode source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that cycle.
- R3: A load-use stall lasts one cycle. Once the load has moved to memory and a bubble occupies execute, a non-branch consumer in decode is not held. When that consumer reaches execute with the load in writeback, its execute select is 2.
- R4: Execute-stage select codes are 0 = value from the decode/execute register, 1 = result held in the execute/memory register, 2 = result held in the memory/writeback register. Code 1 requires `mem_wen`=1 and `mem_rd` equal to the source. Code 2 requires `wb_wen`=1 and `wb_rd` equal to the source.
- R5: When both the memory and the writeback stages write the source register, the select is 1 (youngest value) in both the decode and the execute multiplexers.
- R6: Register 0 never causes a hold and never yields a nonzero select.
- R7: Decode-stage select codes use the same encoding. An ALU result in memory gives 1, a writeback result gives 2, and a load in memory matching the source gives 0.
- R8: A branch in decode (`id_is_branch`=1) holds when a used source matches a writing instruction of any kind in execute, or a load in memory.
- R9: `ifid_squash` is 1 exactly when a branch in decode is taken and no hold is requested in that cycle.
- R10: A decode source whose use flag is 0 causes no hold and gets select 0, whatever its register number.
- R11: An ALU (non-load) producer in execute does not hold a non-branch consumer in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| id_br_taken | input | 1 | Branch outcome computed in decode |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode latch |
| idex_bubble | output | 1 | Load the all-zero nop into decode/execute |
| ifid_squash | output | 1 | Overwrite the fetch/decode instruction with the nop |
| id_fwd_a | output | 2 | Decode bypass select, first source |
| id_fwd_b | output | 2 | Decode bypass select, second source |
| ex_fwd_a | output | 2 | Execute bypass select, first source |
| ex_fwd_b | output | 2 | Execute bypass select, second source |

## Verification
The bypass selects are tried with a match in memory only, in writeback only, in both, and with the memory write enable low. These cases separate the three sources and show the youngest-wins order. Hold cases put a load and an ALU producer in execute, first against a plain consumer and then against a branch, and a load in memory against a branch. This shows which producer kinds interlock which consumers. Register 0 and cleared use flags are applied with otherwise matching numbers, to show that they are masked. A three-step load-use sequence then checks that the hold releases after one cycle and hands the value to the writeback bypass.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Widest register index the helper functions accept.
  localparam int unsigned RA_MAX = 8;

  typedef logic [RA_MAX-1:0] ra_t;

  // Operand source select shared by decode and execute multiplexers.
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  // A stage produces a usable register value only when it writes a nonzero index.
  function automatic logic writes_reg(input logic wen, input ra_t rd);
    return wen && (rd != '0);
  endfunction

  // Consumer source rs depends on producer destination rd.
  function automatic logic src_hit(input logic wen, input ra_t rd,
                                   input ra_t rs, input logic use_src);
    return use_src && writes_reg(wen, rd) && (rd == rs);
  endfunction

endpackage

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output fwd_sel_e          sel
);

  logic mem_hit;
  logic wb_hit;

  assign mem_hit = src_hit(mem_wen, ra_t'(mem_rd), ra_t'(rs), 1'b1);
  assign wb_hit  = src_hit(wb_wen,  ra_t'(wb_rd),  ra_t'(rs), 1'b1);

  // Youngest producer first.
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

endmodule

// File: rtl/hz_id_fwd.sv
module hz_id_fwd
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic              use_src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_ld,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output fwd_sel_e          sel,
  output logic              mem_ld_hit
);

  logic mem_alu_hit;
  logic wb_hit;

  assign mem_alu_hit = src_hit(mem_wen && !mem_ld, ra_t'(mem_rd), ra_t'(rs), use_src);
  assign mem_ld_hit  = src_hit(mem_wen &&  mem_ld, ra_t'(mem_rd), ra_t'(rs), use_src);
  assign wb_hit      = src_hit(wb_wen, ra_t'(wb_rd), ra_t'(rs), use_src);

  // A load still in memory shadows any older writeback value; the
  // execute-stage bypass supplies it one cycle later.
  always_comb begin
    if (mem_alu_hit)     sel = FWD_MEM;
    else if (mem_ld_hit) sel = FWD_RF;
    else if (wb_hit)     sel = FWD_WB;
    else                 sel = FWD_RF;
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSRC   = 2
) (
  input  logic [REG_AW-1:0] id_rs      [NSRC],
  input  logic              id_use     [NSRC],
  input  logic              id_br,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_ld,
  input  logic              mem_ld_hit [NSRC],
  output logic              load_use_hit,
  output logic              branch_wait_hit,
  output logic              stall_req
);

  logic ex_dep;
  logic mem_ld_dep;

  always_comb begin
    ex_dep     = 1'b0;
    mem_ld_dep = 1'b0;
    for (int i = 0; i < int'(NSRC); i++) begin
      ex_dep     = ex_dep | src_hit(ex_wen, ra_t'(ex_rd), ra_t'(id_rs[i]), id_use[i]);
      mem_ld_dep = mem_ld_dep | mem_ld_hit[i];
    end
  end

  // Loaded data appears only after memory; branch operands are compared in
  // decode, so any execute producer, or a load in memory, must be waited for.
  assign load_use_hit    = ex_ld && ex_dep;
  assign branch_wait_hit = id_br && (ex_dep || mem_ld_dep);
  assign stall_req       = load_use_hit || branch_wait_hit;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic              id_is_branch,
  input  logic              id_br_taken,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ifid_squash,
  output logic [1:0]        id_fwd_a,
  output logic [1:0]        id_fwd_b,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b
);

  localparam int unsigned NSRC = 2;

  logic [REG_AW-1:0] id_rs_v    [NSRC];
  logic              id_use_v   [NSRC];
  logic [REG_AW-1:0] ex_rs_v    [NSRC];
  fwd_sel_e          id_sel     [NSRC];
  fwd_sel_e          ex_sel     [NSRC];
  logic              mem_ld_hit [NSRC];

  // Named internal events, observed by the bound checker.
  logic load_use_hit;
  logic branch_wait_hit;
  logic stall_req;

  assign id_rs_v[0]  = id_rs1;
  assign id_rs_v[1]  = id_rs2;
  assign id_use_v[0] = id_use_rs1;
  assign id_use_v[1] = id_use_rs2;
  assign ex_rs_v[0]  = ex_rs1;
  assign ex_rs_v[1]  = ex_rs2;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_id_fwd #(.REG_AW(REG_AW)) u_id_fwd (
      .rs         (id_rs_v[s]),
      .use_src    (id_use_v[s]),
      .mem_rd     (mem_rd),
      .mem_wen    (mem_wen),
      .mem_ld     (mem_is_load),
      .wb_rd      (wb_rd),
      .wb_wen     (wb_wen),
      .sel        (id_sel[s]),
      .mem_ld_hit (mem_ld_hit[s])
    );

    hz_ex_fwd #(.REG_AW(REG_AW)) u_ex_fwd (
      .rs      (ex_rs_v[s]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (ex_sel[s])
    );
  end

  hz_interlock #(.REG_AW(REG_AW), .NSRC(NSRC)) u_lock (
    .id_rs           (id_rs_v),
    .id_use          (id_use_v),
    .id_br           (id_is_branch),
    .ex_rd           (ex_rd),
    .ex_wen          (ex_wen),
    .ex_ld           (ex_is_load),
    .mem_ld_hit      (mem_ld_hit),
    .load_use_hit    (load_use_hit),
    .branch_wait_hit (branch_wait_hit),
    .stall_req       (stall_req)
  );

  assign pc_hold     = stall_req;
  assign ifid_hold   = stall_req;
  assign idex_bubble = stall_req;
  // A held branch has not resolved yet, so the wrong-path fetch stays.
  assign ifid_squash = id_is_branch && id_br_taken && !stall_req;

  assign id_fwd_a = id_sel[0];
  assign id_fwd_b = id_sel[1];
  assign ex_fwd_a = ex_sel[0];
  assign ex_fwd_b = ex_sel[1];

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_use_rs1,
  input logic              id_use_rs2,
  input logic              id_is_branch,
  input logic              id_br_taken,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_wen,
  input logic              ex_is_load,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wen,
  input logic              mem_is_load,
  input logic              pc_hold,
  input logic              idex_bubble,
  input logic              ifid_squash,
  input logic [1:0]        id_fwd_a,
  input logic [1:0]        id_fwd_b,
  input logic [1:0]        ex_fwd_a,
  input logic              load_use_hit,
  input logic              branch_wait_hit
);

  always_comb begin
    // R1
    idle_no_hold_chk: assert (ex_wen || (mem_wen && mem_is_load) || !pc_hold)
      else $error("hold without any producer in execute or memory");
    // R2
    load_use_hold_chk: assert (!(ex_is_load && ex_wen && ex_rd != '0 && id_use_rs1 &&
                                 id_rs1 == ex_rd) || (pc_hold && idex_bubble))
      else $error("load-use on first source not held");
    // R9
    squash_vs_hold_chk: assert (!(ifid_squash && pc_hold))
      else $error("squash while held");
    // R9
    squash_taken_chk: assert (!(id_is_branch && id_br_taken && !pc_hold) || ifid_squash)
      else $error("taken branch not squashing");
    // R5
    ex_prio_chk: assert (!(mem_wen && mem_rd == ex_rs1 && ex_rs1 != '0) || ex_fwd_a == 2'd1)
      else $error("memory-stage producer not preferred");
    // R6
    r0_select_chk: assert (ex_rs1 != '0 || ex_fwd_a == 2'd0)
      else $error("register 0 bypassed");
    // R8
    branch_wait_chk: assert (!branch_wait_hit || (id_is_branch && pc_hold))
      else $error("branch wait without branch or hold");
    // R2
    load_use_src_chk: assert (!load_use_hit || (ex_is_load && ex_rd != '0))
      else $error("load-use event without load");
    // R10
    unused_src_chk: assert ((id_use_rs1 || id_fwd_a == 2'd0) && (id_use_rs2 || id_fwd_b == 2'd0))
      else $error("unused source given a bypass");
  end

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .id_rs1          (id_rs1),
  .id_rs2          (id_rs2),
  .id_use_rs1      (id_use_rs1),
  .id_use_rs2      (id_use_rs2),
  .id_is_branch    (id_is_branch),
  .id_br_taken     (id_br_taken),
  .ex_rs1          (ex_rs1),
  .ex_rd           (ex_rd),
  .ex_wen          (ex_wen),
  .ex_is_load      (ex_is_load),
  .mem_rd          (mem_rd),
  .mem_wen         (mem_wen),
  .mem_is_load     (mem_is_load),
  .pc_hold         (pc_hold),
  .idex_bubble     (idex_bubble),
  .ifid_squash     (ifid_squash),
  .id_fwd_a        (id_fwd_a),
  .id_fwd_b        (id_fwd_b),
  .ex_fwd_a        (ex_fwd_a),
  .load_use_hit    (load_use_hit),
  .branch_wait_hit (branch_wait_hit)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [3:0]    req;
    logic [AW-1:0] id_rs1, id_rs2;
    logic          use1, use2, br, tk;
    logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic          ex_wen, ex_ld;
    logic [AW-1:0] mem_rd;
    logic          mem_wen, mem_ld;
    logic [AW-1:0] wb_rd;
    logic          wb_wen;
    logic          e_stall, e_squash;
    logic [1:0]    e_ida, e_idb, e_exa, e_exb;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1,  1,2,1,1,0,0, 3,4,5,1,0, 6,1,0, 7,1, 0,0,0,0,0,0}, // R1 idle
    '{2,  5,2,1,1,0,0, 3,4,5,1,1, 6,1,0, 7,1, 1,0,0,0,0,0}, // R2 first source
    '{2,  1,5,1,1,0,0, 3,4,5,1,1, 6,1,0, 7,1, 1,0,0,0,0,0}, // R2 second source
    '{4,  1,2,1,1,0,0, 6,7,5,1,0, 6,1,0, 7,1, 0,0,0,0,1,2}, // R4 mem and wb
    '{4,  1,2,1,1,0,0, 3,4,5,1,0, 3,0,0, 3,1, 0,0,0,0,2,0}, // R4 mem wen low
    '{5,  1,2,1,1,0,0, 9,9,5,1,0, 9,1,0, 9,1, 0,0,0,0,1,1}, // R5 execute
    '{5,  9,9,1,1,0,0, 3,4,5,1,0, 9,1,0, 9,1, 0,0,1,1,0,0}, // R5 decode
    '{6,  0,0,1,1,1,1, 0,0,0,1,1, 0,1,0, 0,1, 0,1,0,0,0,0}, // R6 register 0
    '{7,  6,7,1,1,0,0, 3,4,5,1,0, 6,1,0, 7,1, 0,0,1,2,0,0}, // R7 decode bypass
    '{8,  5,2,1,1,1,1, 3,4,5,1,0, 6,1,0, 7,1, 1,0,0,0,0,0}, // R8 ALU in execute
    '{8,  1,6,1,1,1,0, 3,4,5,1,0, 6,1,1, 7,1, 1,0,0,0,0,0}, // R8 load in memory
    '{9,  6,7,1,1,1,1, 3,4,5,1,0, 6,1,0, 7,1, 0,1,1,2,0,0}, // R9 taken, free
    '{10, 5,6,0,0,1,0, 3,4,5,1,1, 6,1,0, 7,1, 0,0,0,0,0,0}, // R10 unused sources
    '{11, 5,2,1,1,0,0, 3,4,5,1,0, 6,1,0, 7,1, 0,0,0,0,0,0}  // R11 ALU producer
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  int total = 0;
  int bad = 0;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, id_is_branch, id_br_taken;
  logic ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
  logic pc_hold, ifid_hold, idex_bubble, ifid_squash;
  logic [1:0] id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) u_dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .ifid_squash(ifid_squash), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
  );

  task automatic drive(input vec_t v);
    id_rs1 = v.id_rs1; id_rs2 = v.id_rs2; id_use_rs1 = v.use1; id_use_rs2 = v.use2;
    id_is_branch = v.br; id_br_taken = v.tk;
    ex_rs1 = v.ex_rs1; ex_rs2 = v.ex_rs2; ex_rd = v.ex_rd; ex_wen = v.ex_wen; ex_is_load = v.ex_ld;
    mem_rd = v.mem_rd; mem_wen = v.mem_wen; mem_is_load = v.mem_ld;
    wb_rd = v.wb_rd; wb_wen = v.wb_wen;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] observed();
    return {4'd0, pc_hold, ifid_hold, idex_bubble, ifid_squash,
            id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b};
  endfunction

  function automatic logic [15:0] wanted(input vec_t v);
    return {4'd0, v.e_stall, v.e_stall, v.e_stall, v.e_squash,
            v.e_ida, v.e_idb, v.e_exa, v.e_exb};
  endfunction

  vec_t idle_v;
  vec_t step_v;

  initial begin
    idle_v = '0;
    drive(idle_v);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state: idle inputs give no hold, squash or bypass
    check("R1 reset idle", observed(), 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), observed(), wanted(VEC[i]));
    end

    // R3 load-use sequence, cycle 1: load r8 in execute, add reads r8
    @(negedge clk);
    step_v = '0;
    step_v.id_rs1 = 8; step_v.use1 = 1; step_v.id_rs2 = 2; step_v.use2 = 1;
    step_v.ex_rd = 8; step_v.ex_wen = 1; step_v.ex_ld = 1;
    drive(step_v);
    #1;
    check("R3 stall cycle hold", {13'd0, pc_hold, ifid_hold, idex_bubble}, 16'h0007);
    // cycle 2: bubble in execute, load in memory, add still in decode
    @(negedge clk);
    step_v.ex_rd = 0; step_v.ex_wen = 0; step_v.ex_ld = 0;
    step_v.mem_rd = 8; step_v.mem_wen = 1; step_v.mem_ld = 1;
    drive(step_v);
    #1;
    check("R3 released after one cycle", {12'd0, pc_hold, ifid_hold, idex_bubble, 1'b0}, 16'h0000);
    check("R3 decode select while load in memory", {14'd0, id_fwd_a}, 16'd0);
    // cycle 3: add in execute, load in writeback
    @(negedge clk);
    step_v = '0;
    step_v.ex_rs1 = 8; step_v.ex_rs2 = 2; step_v.ex_rd = 9; step_v.ex_wen = 1;
    step_v.wb_rd = 8; step_v.wb_wen = 1;
    drive(step_v);
    #1;
    check("R3 writeback bypass to execute", {12'd0, ex_fwd_a, ex_fwd_b}, 16'h0008);

    // R8 branch behind a load in execute holds too
    @(negedge clk);
    step_v = '0;
    step_v.id_rs1 = 4; step_v.use1 = 1; step_v.br = 1; step_v.tk = 1;
    step_v.ex_rd = 4; step_v.ex_wen = 1; step_v.ex_ld = 1;
    drive(step_v);
    #1;
    check("R8 branch behind load, R9 no squash", {14'd0, pc_hold, ifid_squash}, 16'h0002);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule